// File: doc/BRIEF.md
# EEPROM Image Loader with Checksum Validation

This block keeps a shadow copy of a 64-word, 16-bit configuration EEPROM and serves requests from it. A request is a word lookup, a 32-bit assembly-number lookup, a single-word write, or a checksum repair. Lookups are answered from the shadow copy when its cached signature is valid. Otherwise the block first reloads the whole image.

The block does not drive the EEPROM pins. It issues one command at a time to a serial master through a command port and waits for that command's completion pulse. A reload is accepted only if two conditions hold: the 16-bit wrapping sum of all 64 words equals 0xBABA, and the signature field of the init-control word holds the valid pattern. A failed checksum, a master error during a reload, or any write leaves the cache invalid, so the next lookup reloads the image.

The controller is a single FSM with these states:
- `ST_IDLE`: accepts a request.
- `ST_LD_ISSUE` / `ST_LD_WAIT`: fetch one image word.
- `ST_LD_CHECK`: judges the checksum and the signature.
- `ST_SUM_ISSUE` / `ST_SUM_WAIT`: read words for a checksum repair.
- `ST_WR_ISSUE` / `ST_WR_WAIT`: write one word.
- `ST_FINISH`: presents the response for one cycle.

The transitions are:
- IDLE goes to FINISH on a cache hit or an out-of-range index.
- IDLE goes to LD_ISSUE on a lookup that misses the cache.
- IDLE goes to WR_ISSUE on a write.
- IDLE goes to SUM_ISSUE on a repair.
- LD_WAIT goes back to LD_ISSUE for the next word, to LD_CHECK after word 63, and to FINISH on an error.
- SUM_WAIT goes back to SUM_ISSUE for the next word, to WR_ISSUE after word 62, and to FINISH on an error.
- WR_WAIT goes to FINISH.
- LD_CHECK goes to FINISH.
- FINISH goes to IDLE.

Top module: `eel_image_loader`

## Requirements
- R1: A reload issues read commands to addresses 0 through 63 in ascending order and stores every returned word in the shadow copy.
- R2: A reload succeeds only when the modulo-65536 sum of the 64 words is 0xBABA. A successful word lookup returns the word at that index with `rsp_ok`=1.
- R3: When the sum is wrong, the lookup fails and bits 15:14 of shadow word 10 are cleared. Every later lookup therefore performs a full reload again.
- R4: When the sum is right but bits 15:14 of word 10 are not 2'b01, the lookup fails.
- R5: When cached word 10 holds signature 2'b01, an in-range lookup answers one cycle after the request and issues no master command.
- R6: A word lookup with index 64 or higher answers zero with `rsp_ok`=0, one cycle after the request, and issues no master command.
- R7: An assembly-number lookup (`req_op`=1) returns {word 9, word 8}. It returns zero when the image cannot be validated.
- R8: A checksum repair (`req_op`=3) reads words 0 to 62 and writes 0xBABA minus their sum to word 63. The response carries that value.
- R9: A write (`req_op`=2) stores `req_wdata` at index `req_idx[5:0]`, reports `rsp_ok`=1, and invalidates the cache, so the next lookup reloads.
- R10: A master error during a reload aborts it after that command, reports failure, and leaves the cache invalid.
- R11: After reset the block is idle with no command pending. Requests made while `busy` is high are ignored. `m_req` is a single-cycle pulse and occurs only while busy.
- R12: Every response with `rsp_ok`=0 carries all-zero data.

The `req_op` encoding is:
- 0: word lookup
- 1: assembly number
- 2: write
- 3: checksum repair

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | Operation code |
| req_idx | input | 7 | Word index |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Block is processing a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Response success |
| rsp_data | output | 32 | Response data |
| m_req | output | 1 | Command pulse to the serial master |
| m_we | output | 1 | Command is a write |
| m_addr | output | 6 | Command word address |
| m_wdata | output | 16 | Command write data |
| m_done | input | 1 | Command completion pulse |
| m_rdata | input | 16 | Read data, valid with m_done |
| m_err | input | 1 | Command failed, valid with m_done |

## Verification
A cache hit and an out-of-range lookup answer exactly one cycle after the request edge. The checker asserts that cycle, and the bench's monitor pops the scoreboard in whatever cycle `rsp_valid` appears.

Every other result waits for master traffic, so its timing depends on the master's latency. For these results the scoreboard is tied to the response pulse rather than to a fixed cycle count. The bench also counts master reads between requests to confirm reload-or-not behaviour.

// File: rtl/eel_pkg.sv
package eel_pkg;
    typedef enum logic [1:0] {
        OP_RD_WORD = 2'd0,
        OP_RD_ASSY = 2'd1,
        OP_WRITE   = 2'd2,
        OP_FIX_SUM = 2'd3
    } eel_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LD_ISSUE,
        ST_LD_WAIT,
        ST_LD_CHECK,
        ST_SUM_ISSUE,
        ST_SUM_WAIT,
        ST_WR_ISSUE,
        ST_WR_WAIT,
        ST_FINISH
    } eel_state_e;
endpackage

// File: rtl/eel_accum.sv
module eel_accum #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] add_val,
    output logic [DATA_W-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum <= '0;
        else if (clr)
            sum <= '0;
        else if (add_en)
            sum <= sum + add_val;
    end
endmodule

// File: rtl/eel_shadow.sv
module eel_shadow #(
    parameter int          ADDR_W    = 6,
    parameter int          DATA_W    = 16,
    parameter int          SIG_WORD  = 10,
    parameter int          SIG_HI    = 15,
    parameter logic [1:0]  SIG_VALID = 2'b01,
    parameter int          ASSY_LO   = 8,
    parameter int          ASSY_HI   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sig_clr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] assy_lo,
    output logic [DATA_W-1:0] assy_hi,
    output logic              sig_ok
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            if (wr_en) mem[wr_addr] <= wr_data;
            if (sig_clr) mem[SIG_WORD][SIG_HI -: 2] <= 2'b00;
        end
    end

    assign rd_data = mem[rd_addr];
    assign assy_lo = mem[ASSY_LO];
    assign assy_hi = mem[ASSY_HI];
    assign sig_ok  = (mem[SIG_WORD][SIG_HI -: 2] == SIG_VALID);
endmodule

// File: rtl/eel_image_loader.sv
module eel_image_loader #(
    parameter int          ADDR_W    = 6,
    parameter int          DATA_W    = 16,
    parameter logic [15:0] MAGIC     = 16'hBABA,
    parameter int          SIG_WORD  = 10,
    parameter int          SIG_HI    = 15,
    parameter logic [1:0]  SIG_VALID = 2'b01,
    parameter int          ASSY_LO   = 8,
    parameter int          ASSY_HI   = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W:0]     req_idx,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                busy,
    output logic                rsp_valid,
    output logic                rsp_ok,
    output logic [2*DATA_W-1:0] rsp_data,
    output logic                m_req,
    output logic                m_we,
    output logic [ADDR_W-1:0]   m_addr,
    output logic [DATA_W-1:0]   m_wdata,
    input  logic                m_done,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic                m_err
);
    import eel_pkg::*;

    localparam int              WORDS  = 1 << ADDR_W;
    localparam int              IDX_W  = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);
    localparam logic [ADDR_W-1:0] PRE  = ADDR_W'(WORDS - 2);

    eel_state_e          state, nxt;
    eel_op_e             op_q;
    logic [ADDR_W-1:0]   rd_idx_q;
    logic [ADDR_W-1:0]   ptr;
    logic [DATA_W-1:0]   wdata_q;
    logic                fail_q;

    logic [DATA_W-1:0]   acc_sum, rd_data, assy_lo, assy_hi;
    logic                sig_ok, acc_clr, acc_add, sh_wr, sh_clr;
    logic                req_take, idx_oob, sum_bad;

    assign req_take = (state == ST_IDLE) && req_valid;
    assign idx_oob  = (req_idx >= IDX_W'(WORDS));
    assign sum_bad  = (acc_sum != MAGIC);

    eel_accum #(.DATA_W(DATA_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add_en(acc_add),
        .add_val(m_rdata), .sum(acc_sum)
    );

    eel_shadow #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_WORD(SIG_WORD), .SIG_HI(SIG_HI),
        .SIG_VALID(SIG_VALID), .ASSY_LO(ASSY_LO), .ASSY_HI(ASSY_HI)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(sh_wr), .wr_addr(ptr), .wr_data(m_rdata),
        .sig_clr(sh_clr), .rd_addr(rd_idx_q), .rd_data(rd_data),
        .assy_lo(assy_lo), .assy_hi(assy_hi), .sig_ok(sig_ok)
    );

    // shadow and accumulator strobes
    assign acc_clr = req_take;
    assign acc_add = ((state == ST_LD_WAIT) || (state == ST_SUM_WAIT)) && m_done && !m_err;
    assign sh_wr   = (state == ST_LD_WAIT) && m_done && !m_err;
    assign sh_clr  = ((state == ST_LD_WAIT) && m_done && m_err)
                   || ((state == ST_LD_CHECK) && sum_bad)
                   || ((state == ST_WR_WAIT) && m_done);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                unique case (eel_op_e'(req_op))
                    OP_RD_WORD: nxt = (idx_oob || sig_ok) ? ST_FINISH : ST_LD_ISSUE;
                    OP_RD_ASSY: nxt = sig_ok ? ST_FINISH : ST_LD_ISSUE;
                    OP_WRITE:   nxt = ST_WR_ISSUE;
                    OP_FIX_SUM: nxt = ST_SUM_ISSUE;
                    default:    nxt = ST_IDLE;
                endcase
            end
            ST_LD_ISSUE:  nxt = ST_LD_WAIT;
            ST_LD_WAIT:   if (m_done) nxt = m_err ? ST_FINISH
                                              : (ptr == LAST) ? ST_LD_CHECK : ST_LD_ISSUE;
            ST_LD_CHECK:  nxt = ST_FINISH;
            ST_SUM_ISSUE: nxt = ST_SUM_WAIT;
            ST_SUM_WAIT:  if (m_done) nxt = m_err ? ST_FINISH
                                              : (ptr == PRE) ? ST_WR_ISSUE : ST_SUM_ISSUE;
            ST_WR_ISSUE:  nxt = ST_WR_WAIT;
            ST_WR_WAIT:   if (m_done) nxt = ST_FINISH;
            ST_FINISH:    nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // request context and progress registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_RD_WORD;
            rd_idx_q <= '0;
            ptr      <= '0;
            wdata_q  <= '0;
            fail_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    op_q     <= eel_op_e'(req_op);
                    rd_idx_q <= req_idx[ADDR_W-1:0];
                    wdata_q  <= req_wdata;
                    ptr      <= (eel_op_e'(req_op) == OP_WRITE) ? req_idx[ADDR_W-1:0] : '0;
                    fail_q   <= (eel_op_e'(req_op) == OP_RD_WORD) && idx_oob;
                end
                ST_LD_WAIT: if (m_done) begin
                    if (m_err)             fail_q <= 1'b1;
                    else if (ptr != LAST)  ptr    <= ptr + 1'b1;
                end
                ST_LD_CHECK: if (sum_bad || !sig_ok) fail_q <= 1'b1;
                ST_SUM_WAIT: if (m_done) begin
                    if (m_err) fail_q <= 1'b1;
                    else if (ptr == PRE) begin
                        wdata_q <= MAGIC - (acc_sum + m_rdata);
                        ptr     <= LAST;
                    end else ptr <= ptr + 1'b1;
                end
                ST_WR_WAIT: if (m_done) fail_q <= m_err;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        m_req     = (state == ST_LD_ISSUE) || (state == ST_SUM_ISSUE) || (state == ST_WR_ISSUE);
        m_we      = (state == ST_WR_ISSUE);
        m_addr    = ptr;
        m_wdata   = wdata_q;
        rsp_valid = (state == ST_FINISH);
        rsp_ok    = rsp_valid && !fail_q;
        rsp_data  = '0;
        if (rsp_valid && !fail_q) begin
            unique case (op_q)
                OP_RD_WORD: rsp_data = {{DATA_W{1'b0}}, rd_data};
                OP_RD_ASSY: rsp_data = {assy_hi, assy_lo};
                OP_WRITE,
                OP_FIX_SUM: rsp_data = {{DATA_W{1'b0}}, wdata_q};
                default:    rsp_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/eel_image_loader_chk.sv
module eel_image_loader_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          req_op,
    input logic [ADDR_W:0]     req_idx,
    input logic                busy,
    input logic                rsp_valid,
    input logic                rsp_ok,
    input logic [2*DATA_W-1:0] rsp_data,
    input logic                m_req,
    input logic                sig_ok
);
    localparam int WORDS = 1 << ADDR_W;

    logic rd_take;
    assign rd_take = req_valid && !busy && (req_op == 2'd0);

    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |=> !m_req);

    a_r11_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> busy);

    a_r6_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && (req_idx >= (ADDR_W+1)'(WORDS))) |=> (rsp_valid && !rsp_ok && rsp_data == '0));

    a_r5_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && (req_idx < (ADDR_W+1)'(WORDS)) && sig_ok) |=> (rsp_valid && rsp_ok && !m_req));

    a_r12_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_data == '0));
endmodule

bind eel_image_loader eel_image_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
    .m_req(m_req), .sig_ok(sig_ok)
);

// File: tb/eel_image_loader_bench.sv
`timescale 1ns/1ps
module eel_image_loader_bench;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [6:0]  req_idx = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, rsp_valid, rsp_ok, m_req, m_we;
    logic [31:0] rsp_data;
    logic [5:0]  m_addr;
    logic [15:0] m_wdata;
    logic        m_done = 1'b0;
    logic [15:0] m_rdata = '0;
    logic        m_err = 1'b0;

    always #10 clk = ~clk;

    eel_image_loader u_eel_image_loader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_data(rsp_data), .m_req(m_req), .m_we(m_we),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_done(m_done), .m_rdata(m_rdata),
        .m_err(m_err)
    );

    // behavioural serial master + EEPROM
    logic [15:0] rom [64];
    int          cnt = 0;
    logic [5:0]  p_addr;
    logic        p_we;
    logic [15:0] p_wdata;
    int          reads = 0;
    int          err_addr = -1;
    int          order_bad = 0;
    int          next_exp = 0;

    always @(posedge clk) begin
        m_done <= 1'b0;
        m_err  <= 1'b0;
        if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                m_done <= 1'b1;
                if (p_we) rom[p_addr] <= p_wdata;
                else begin
                    m_rdata <= rom[p_addr];
                    m_err   <= (int'(p_addr) == err_addr);
                end
            end
        end
        if (m_req) begin
            cnt     <= LAT;
            p_addr  <= m_addr;
            p_we    <= m_we;
            p_wdata <= m_wdata;
            if (!m_we) begin
                reads <= reads + 1;
                if (int'(m_addr) == 0) next_exp = 1;
                else begin
                    if (int'(m_addr) != next_exp) order_bad = order_bad + 1;
                    next_exp = next_exp + 1;
                end
            end
        end
    end

    // scoreboard
    typedef struct {
        logic [31:0] data;
        logic        ok;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   n_rsp = 0;

    task automatic check(input bit cond, input string tag, input longint act, input longint expv);
        n_cmp++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_rsp++;
            if (exp_q.size() == 0) check(1'b0, "R11 unexpected response", rsp_data, 0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_data == e.data && rsp_ok == e.ok, e.tag,
                      {rsp_ok, rsp_data}, {e.ok, e.data});
            end
        end
    end

    task automatic do_req(input logic [1:0] op, input logic [6:0] idx, input logic [15:0] wd,
                          input logic [31:0] ed, input logic eok, input string tag);
        exp_t e;
        e.data = ed; e.ok = eok; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_idx = idx; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    function automatic logic [15:0] sum_to(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + rom[i];
        return s;
    endfunction

    bit done_flag = 0;

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 0);
        finish_run();
    end

    initial begin
        int r0;
        int rs;
        for (int i = 0; i < 64; i++) rom[i] = 16'((i * 16'h0135) ^ 16'h5A00);
        rom[10] = {2'b01, rom[10][13:0]};
        rom[63] = 16'hBABA - sum_to(63);

        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !rsp_valid && !m_req, "R11 reset idle", {busy, rsp_valid, m_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: first lookup loads whole image
        r0 = reads;
        do_req(2'd0, 7'd5, 16'h0, {16'h0, rom[5]}, 1'b1, "R2 lookup after load");
        check(reads - r0 == 64, "R1 read count", reads - r0, 64);
        check(order_bad == 0, "R1 address order", order_bad, 0);

        // R5: cache hit, no traffic
        r0 = reads;
        do_req(2'd0, 7'd20, 16'h0, {16'h0, rom[20]}, 1'b1, "R5 cached lookup");
        check(reads == r0, "R5 no master reads", reads - r0, 0);

        // R7: assembly number
        do_req(2'd1, 7'd0, 16'h0, {rom[9], rom[8]}, 1'b1, "R7 assembly number");

        // R6: out-of-range
        r0 = reads;
        do_req(2'd0, 7'd70, 16'h0, 32'h0, 1'b0, "R6 index beyond image");
        check(reads == r0, "R6 no master reads", reads - r0, 0);

        // R9: write invalidates
        do_req(2'd2, 7'd3, 16'h1234, 32'h1234, 1'b1, "R9 write response");
        check(rom[3] == 16'h1234, "R9 word stored", rom[3], 16'h1234);
        r0 = reads;
        // R3/R12: sum now wrong
        do_req(2'd0, 7'd3, 16'h0, 32'h0, 1'b0, "R3 checksum failure");
        check(reads - r0 == 64, "R9 reload after write", reads - r0, 64);
        r0 = reads;
        do_req(2'd0, 7'd4, 16'h0, 32'h0, 1'b0, "R3 still invalid");
        check(reads - r0 == 64, "R3 reload again", reads - r0, 64);
        do_req(2'd1, 7'd0, 16'h0, 32'h0, 1'b0, "R7 invalid image gives zero");

        // R8: repair
        rs = 16'hBABA - sum_to(63);
        do_req(2'd3, 7'd0, 16'h0, {16'h0, 16'(rs)}, 1'b1, "R8 repair value");
        check(rom[63] == 16'(rs), "R8 word 63 written", rom[63], rs);
        do_req(2'd0, 7'd3, 16'h0, 32'h1234, 1'b1, "R2 lookup after repair");

        // R4: bad signature
        do_req(2'd2, 7'd10, {2'b10, rom[10][13:0]}, {16'h0, 2'b10, rom[10][13:0]}, 1'b1, "R9 sig write");
        rs = 16'hBABA - sum_to(63);
        do_req(2'd3, 7'd0, 16'h0, {16'h0, 16'(rs)}, 1'b1, "R8 repair two");
        do_req(2'd0, 7'd1, 16'h0, 32'h0, 1'b0, "R4 signature mismatch");
        do_req(2'd2, 7'd10, {2'b01, rom[10][13:0]}, {16'h0, 2'b01, rom[10][13:0]}, 1'b1, "R9 sig restore");
        rs = 16'hBABA - sum_to(63);
        do_req(2'd3, 7'd0, 16'h0, {16'h0, 16'(rs)}, 1'b1, "R8 repair three");

        // R10: master error
        err_addr = 30;
        r0 = reads;
        do_req(2'd0, 7'd1, 16'h0, 32'h0, 1'b0, "R10 master error");
        check(reads - r0 == 31, "R10 aborted at error", reads - r0, 31);
        err_addr = -1;
        r0 = reads;
        do_req(2'd0, 7'd1, 16'h0, {16'h0, rom[1]}, 1'b1, "R10 recovery lookup");
        check(reads - r0 == 64, "R10 cache was invalid", reads - r0, 64);

        // R11: requests while busy ignored
        do_req(2'd2, 7'd2, rom[2], {16'h0, rom[2]}, 1'b1, "R11 invalidate");
        rs = n_rsp;
        begin
            exp_t e;
            e.data = {16'h0, rom[7]}; e.ok = 1'b1; e.tag = "R11 lookup while busy";
            exp_q.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_idx = 7'd7;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_idx = 7'd9;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(n_rsp - rs == 1, "R11 one response", n_rsp - rs, 1);
        check(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);

        finish_run();
    end
endmodule